// File: doc/BRIEF.md
# Outstanding Miss Tracker

This block keeps a small table of cache misses that are still in flight. Each allocation takes the lowest free slot and records a block address, a secure-space bit, a thread tag, an earliest issue time and whether a reply will come back. Lookups search the table for a slot with the same address and secure bit, so that a new miss to a block already being fetched can join the existing request rather than start a second one.

Slots that have not yet gone downstream wait in an age-ordered issue queue. The head of that queue is offered on the issue port once the head's time has come, measured against the `now_i` time input. The controller then reports back through a single command port. It can mark a slot as sent, send a slot again, move a slot to the front, free a slot, or drop every unsent slot that belongs to one thread. Two thresholds set the flow control. One sets `full_o`, which stops further allocation. The other sets `can_prefetch_o`, which keeps a margin of slots for demand misses.

Top module: `mshr_file`

## Requirements
- R1: The table holds N_REQ+RESERVE-1 slots, and `alloc_cnt_o` always equals the number of occupied slots. With the default parameters (4, 2, 1), four allocations fit before `full_o` rises.
- R2: `full_o` is high exactly when `alloc_cnt_o` > slots−RESERVE. An allocate command issued while `full_o` is high changes no state.
- R3: `can_prefetch_o` is high exactly when `alloc_cnt_o` < slots−(RESERVE+DEMAND_RES).
- R4: A lookup hits only a slot whose address and secure bit both match. If several slots match, the lowest index is returned. If none match, `lk_hit_o` is low.
- R5: An allocation (`cmd_op_i`=0) takes the lowest free slot index. That index is shown on `alloc_idx_o` before the command is given.
- R6: `issue_valid_o` is high only when the issue queue is non-empty and the head's ready time is ≤ `now_i`. `next_ready_o` shows the head's ready time, or all ones when the queue is empty (`pending_o` low).
- R7: New allocations join the tail of the issue queue, and the queue keeps age order.
- R8: Mark-sent (`cmd_op_i`=1) removes an unsent slot from the queue. If a reply is expected, the slot stays occupied and `insvc_cnt_o` increases by one. If no reply is expected, the slot is freed instead.
- R9: Resend (`cmd_op_i`=2) moves a sent slot back to the tail of the queue and decreases `insvc_cnt_o` by one.
- R10: Move-to-front (`cmd_op_i`=3) puts an unsent slot at the head of the queue. The command has no effect on a sent slot.
- R11: Free (`cmd_op_i`=4) releases an occupied slot. A sent slot also leaves the in-service count, and an unsent slot also leaves the queue.
- R12: Squash (`cmd_op_i`=5) frees every unsent slot whose thread tag equals `cmd_tid_i`. Sent slots of that thread stay occupied.
- R13: After reset the table is empty: both counts are 0, `full_o` is low, `can_prefetch_o` is high, the queue is empty, and `alloc_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_i | input | TIME_W | Current time, compared against ready times |
| cmd_valid_i | input | 1 | Command strobe, at most one command per cycle |
| cmd_op_i | input | 3 | Command code (0..5, see requirements) |
| cmd_idx_i | input | IDX_W | Target slot for commands 1 to 4 |
| cmd_tid_i | input | TID_W | Thread tag for an allocation or a squash |
| alloc_addr_i | input | ADDR_W | Block address to allocate |
| alloc_secure_i | input | 1 | Secure-space bit to allocate |
| alloc_ready_i | input | TIME_W | Earliest issue time of the new slot |
| alloc_resp_i | input | 1 | New slot expects a reply |
| alloc_idx_o | output | IDX_W | Slot the next allocation will take |
| lk_addr_i | input | ADDR_W | Lookup address |
| lk_secure_i | input | 1 | Lookup secure bit |
| lk_hit_o | output | 1 | Lookup found a slot |
| lk_idx_o | output | IDX_W | Lowest matching slot |
| issue_valid_o | output | 1 | Head slot may be issued now |
| issue_idx_o | output | IDX_W | Index of the head slot |
| issue_addr_o | output | ADDR_W | Address of the head slot |
| issue_secure_o | output | 1 | Secure bit of the head slot |
| next_ready_o | output | TIME_W | Head ready time, or all ones when the queue is empty |
| pending_o | output | 1 | Issue queue is non-empty |
| full_o | output | 1 | Allocation is blocked |
| can_prefetch_o | output | 1 | A prefetch may allocate |
| alloc_cnt_o | output | CNT_W | Number of occupied slots |
| insvc_cnt_o | output | CNT_W | Number of sent slots awaiting a reply |

## Verification
Commands take effect at the clock edge that samples them. All state-derived outputs (counts, thresholds, the queue head, `alloc_idx_o`) therefore show the new value one edge after the command. The lookup and the issue gate are combinational on the stored state and on `now_i`, so a change to the lookup inputs or to `now_i` is visible in the same cycle. The bench drives every input on the falling edge. It then waits for the next falling edge, so exactly one rising edge has passed, and reads every output at that point.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [2:0] {
    OP_ALLOC  = 3'd0,
    OP_SENT   = 3'd1,
    OP_RESEND = 3'd2,
    OP_FRONT  = 3'd3,
    OP_FREE   = 3'd4,
    OP_SQUASH = 3'd5
  } mshr_op_e;
endpackage

// File: rtl/mshr_first_one.sv
module mshr_first_one #(
  parameter int W     = 4,
  parameter int IDX_W = 2
) (
  input  logic [W-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_match.sv
module mshr_match #(
  parameter int N      = 4,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0][ADDR_W-1:0] addr_i,
  input  logic [N-1:0]             sec_i,
  input  logic [ADDR_W-1:0]        key_addr_i,
  input  logic                     key_sec_i,
  output logic                     hit_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (addr_i[g] == key_addr_i) && (sec_i[g] == key_sec_i);
  end

  mshr_first_one #(.W(N), .IDX_W(IDX_W)) i_pick (
    .vec_i(eq), .found_o(hit_o), .idx_o(idx_o)
  );
endmodule

// File: rtl/mshr_readyq.sv
module mshr_readyq #(
  parameter int N     = 4,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     kill_i,
  input  logic             push_i,
  input  logic             push_front_i,
  input  logic [IDX_W-1:0] push_idx_i,
  output logic [IDX_W-1:0] head_o,
  output logic             nonempty_o
);
  logic [N-1:0][IDX_W-1:0] q_r, q_kept, q_n;
  logic [CNT_W-1:0]        cnt_r, kept, cnt_n;
  logic                    upd;

  always_comb begin
    q_kept = '0;
    kept   = '0;
    for (int i = 0; i < N; i++) begin
      if ((CNT_W'(i) < cnt_r) && !kill_i[q_r[i]]) begin
        q_kept[kept] = q_r[i];
        kept         = kept + 1'b1;
      end
    end
    q_n   = q_kept;
    cnt_n = kept;
    if (push_i) begin
      if (push_front_i) begin
        for (int i = N - 1; i > 0; i--) q_n[i] = q_kept[i-1];
        q_n[0] = push_idx_i;
      end else begin
        q_n[kept] = push_idx_i;
      end
      cnt_n = kept + 1'b1;
    end
  end

  assign upd = push_i || (|kill_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= '0;
    end else if (upd) begin
      cnt_r <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (upd) q_r <= q_n;
  end

  assign head_o     = q_r[0];
  assign nonempty_o = (cnt_r != '0);
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int N_REQ      = 4,
  parameter int RESERVE    = 2,
  parameter int DEMAND_RES = 1,
  parameter int ADDR_W     = 16,
  parameter int TID_W      = 2,
  parameter int TIME_W     = 16,
  localparam int NENT      = N_REQ + RESERVE - 1,
  localparam int IDX_W     = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int CNT_W     = $clog2(NENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_i,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic [TID_W-1:0]  cmd_tid_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              alloc_secure_i,
  input  logic [TIME_W-1:0] alloc_ready_i,
  input  logic              alloc_resp_i,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              lk_secure_i,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic              issue_valid_o,
  output logic [IDX_W-1:0]  issue_idx_o,
  output logic [ADDR_W-1:0] issue_addr_o,
  output logic              issue_secure_o,
  output logic [TIME_W-1:0] next_ready_o,
  output logic              pending_o,
  output logic              full_o,
  output logic              can_prefetch_o,
  output logic [CNT_W-1:0]  alloc_cnt_o,
  output logic [CNT_W-1:0]  insvc_cnt_o
);
  localparam int FULL_LIM = NENT - RESERVE;
  localparam int PREF_LIM = NENT - (RESERVE + DEMAND_RES);

  // slot state
  logic [NENT-1:0]             v_r, v_n, sent_r, sent_n;
  logic [NENT-1:0][ADDR_W-1:0] addr_r;
  logic [NENT-1:0]             sec_r, resp_r;
  logic [NENT-1:0][TID_W-1:0]  tid_r;
  logic [NENT-1:0][TIME_W-1:0] rdy_r;
  logic [CNT_W-1:0]            acnt_r, acnt_n, icnt_r, icnt_n;

  // queue control
  logic [NENT-1:0]  kill;
  logic             push, push_front;
  logic [IDX_W-1:0] push_idx, head;
  logic             free_found, wr_alloc, sel_ok, sel_v, sel_s;
  logic [IDX_W-1:0] free_idx;
  mshr_op_e         op;

  mshr_first_one #(.W(NENT), .IDX_W(IDX_W)) i_free (
    .vec_i(~v_r), .found_o(free_found), .idx_o(free_idx)
  );

  mshr_match #(.N(NENT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_match (
    .valid_i(v_r), .addr_i(addr_r), .sec_i(sec_r),
    .key_addr_i(lk_addr_i), .key_sec_i(lk_secure_i),
    .hit_o(lk_hit_o), .idx_o(lk_idx_o)
  );

  mshr_readyq #(.N(NENT), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_readyq (
    .clk(clk), .rst_n(rst_n), .kill_i(kill), .push_i(push),
    .push_front_i(push_front), .push_idx_i(push_idx),
    .head_o(head), .nonempty_o(pending_o)
  );

  assign op     = mshr_op_e'(cmd_op_i);
  assign sel_ok = ({1'b0, cmd_idx_i} < (IDX_W + 1)'(NENT));
  assign sel_v  = sel_ok && v_r[cmd_idx_i];
  assign sel_s  = sel_ok && sent_r[cmd_idx_i];

  assign full_o         = ({1'b0, acnt_r} > (CNT_W + 1)'(FULL_LIM));
  assign can_prefetch_o = (PREF_LIM > 0) && ({1'b0, acnt_r} < (CNT_W + 1)'(PREF_LIM));

  // next state of the slot table
  always_comb begin
    v_n        = v_r;
    sent_n     = sent_r;
    acnt_n     = acnt_r;
    icnt_n     = icnt_r;
    kill       = '0;
    push       = 1'b0;
    push_front = 1'b0;
    push_idx   = cmd_idx_i;
    wr_alloc   = 1'b0;
    if (cmd_valid_i) begin
      case (op)
        OP_ALLOC: if (!full_o && free_found) begin
          wr_alloc         = 1'b1;
          v_n[free_idx]    = 1'b1;
          sent_n[free_idx] = 1'b0;
          push             = 1'b1;
          push_idx         = free_idx;
          acnt_n           = acnt_r + 1'b1;
        end
        OP_SENT: if (sel_v && !sel_s) begin
          kill[cmd_idx_i] = 1'b1;
          if (resp_r[cmd_idx_i]) begin
            sent_n[cmd_idx_i] = 1'b1;
            icnt_n            = icnt_r + 1'b1;
          end else begin
            v_n[cmd_idx_i] = 1'b0;
            acnt_n         = acnt_r - 1'b1;
          end
        end
        OP_RESEND: if (sel_v && sel_s) begin
          sent_n[cmd_idx_i] = 1'b0;
          icnt_n            = icnt_r - 1'b1;
          push              = 1'b1;
        end
        OP_FRONT: if (sel_v && !sel_s) begin
          kill[cmd_idx_i] = 1'b1;
          push            = 1'b1;
          push_front      = 1'b1;
        end
        OP_FREE: if (sel_v) begin
          v_n[cmd_idx_i] = 1'b0;
          acnt_n         = acnt_r - 1'b1;
          if (sel_s) begin
            sent_n[cmd_idx_i] = 1'b0;
            icnt_n            = icnt_r - 1'b1;
          end else begin
            kill[cmd_idx_i] = 1'b1;
          end
        end
        OP_SQUASH: begin
          for (int i = 0; i < NENT; i++) begin
            if (v_r[i] && !sent_r[i] && (tid_r[i] == cmd_tid_i)) begin
              v_n[i]  = 1'b0;
              kill[i] = 1'b1;
            end
          end
          acnt_n = acnt_r - CNT_W'($countones(kill));
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_r    <= '0;
      sent_r <= '0;
      acnt_r <= '0;
      icnt_r <= '0;
    end else if (cmd_valid_i) begin
      v_r    <= v_n;
      sent_r <= sent_n;
      acnt_r <= acnt_n;
      icnt_r <= icnt_n;
    end
  end

  // payload: written only on an accepted allocation, no reset needed
  always_ff @(posedge clk) begin
    if (wr_alloc) begin
      addr_r[free_idx] <= alloc_addr_i;
      sec_r[free_idx]  <= alloc_secure_i;
      tid_r[free_idx]  <= cmd_tid_i;
      rdy_r[free_idx]  <= alloc_ready_i;
      resp_r[free_idx] <= alloc_resp_i;
    end
  end

  assign alloc_idx_o    = free_idx;
  assign issue_idx_o    = head;
  assign issue_addr_o   = addr_r[head];
  assign issue_secure_o = sec_r[head];
  assign issue_valid_o  = pending_o && (rdy_r[head] <= now_i);
  assign next_ready_o   = pending_o ? rdy_r[head] : {TIME_W{1'b1}};
  assign alloc_cnt_o    = acnt_r;
  assign insvc_cnt_o    = icnt_r;
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int NENT   = 5,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 3,
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NENT-1:0]   v_r,
  input logic [NENT-1:0]   sent_r,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_op_i,
  input logic [TIME_W-1:0] now_i,
  input logic              lk_hit_o,
  input logic [IDX_W-1:0]  lk_idx_o,
  input logic              issue_valid_o,
  input logic [TIME_W-1:0] next_ready_o,
  input logic              pending_o,
  input logic              full_o,
  input logic              can_prefetch_o,
  input logic [CNT_W-1:0]  alloc_cnt_o,
  input logic [CNT_W-1:0]  insvc_cnt_o
);
  a_r1_count_tracks_bitmap: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_cnt_o == CNT_W'($countones(v_r)));

  a_r2_full_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == 3'd0 && full_o) |=> (v_r == $past(v_r)));

  a_r3_prefetch_not_full: assert property (@(posedge clk) disable iff (!rst_n)
    can_prefetch_o |-> !full_o);

  a_r4_hit_is_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit_o |-> v_r[lk_idx_o]);

  a_r6_issue_time_passed: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> (next_ready_o <= now_i));

  a_r6_empty_queue_max: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_o |-> (next_ready_o == {TIME_W{1'b1}} && !issue_valid_o));

  a_r8_sent_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    insvc_cnt_o == CNT_W'($countones(sent_r & v_r)));

  a_r11_sent_only_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    (sent_r & ~v_r) == '0);
endmodule

bind mshr_file mshr_file_chk #(
  .NENT(NENT), .IDX_W(IDX_W), .CNT_W(CNT_W), .TIME_W(TIME_W)
) i_mshr_file_chk (
  .clk(clk), .rst_n(rst_n), .v_r(v_r), .sent_r(sent_r),
  .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .now_i(now_i),
  .lk_hit_o(lk_hit_o), .lk_idx_o(lk_idx_o), .issue_valid_o(issue_valid_o),
  .next_ready_o(next_ready_o), .pending_o(pending_o), .full_o(full_o),
  .can_prefetch_o(can_prefetch_o), .alloc_cnt_o(alloc_cnt_o),
  .insvc_cnt_o(insvc_cnt_o)
);

// File: tb/test_mshr_file.sv
`timescale 1ns/1ps
module test_mshr_file;
  logic        clk, rst_n;
  logic [15:0] now_i;
  logic        cmd_valid_i;
  logic [2:0]  cmd_op_i;
  logic [2:0]  cmd_idx_i;
  logic [1:0]  cmd_tid_i;
  logic [15:0] alloc_addr_i;
  logic        alloc_secure_i;
  logic [15:0] alloc_ready_i;
  logic        alloc_resp_i;
  logic [2:0]  alloc_idx_o;
  logic [15:0] lk_addr_i;
  logic        lk_secure_i;
  logic        lk_hit_o;
  logic [2:0]  lk_idx_o;
  logic        issue_valid_o;
  logic [2:0]  issue_idx_o;
  logic [15:0] issue_addr_o;
  logic        issue_secure_o;
  logic [15:0] next_ready_o;
  logic        pending_o, full_o, can_prefetch_o;
  logic [2:0]  alloc_cnt_o, insvc_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mshr_file i_mshr_file (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one command at a falling edge; results read one rising edge later
  task automatic cmd(input logic [2:0] op, input logic [2:0] idx, input logic [1:0] tid,
                     input logic [15:0] addr, input logic sec, input logic [15:0] rt,
                     input logic resp);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_idx_i = idx; cmd_tid_i = tid;
    alloc_addr_i = addr; alloc_secure_i = sec; alloc_ready_i = rt; alloc_resp_i = resp;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic lookup(string req, input logic [15:0] a, input logic s,
                        input int hit, input int idx);
    lk_addr_i = a; lk_secure_i = s;
    #1;
    check(req, "lk_hit", lk_hit_o, hit);
    if (hit != 0) check(req, "lk_idx", lk_idx_o, idx);
  endtask

  task automatic t_reset;
    check("R13", "alloc_cnt", alloc_cnt_o, 0);
    check("R13", "insvc_cnt", insvc_cnt_o, 0);
    check("R13", "full", full_o, 0);
    check("R13", "can_prefetch", can_prefetch_o, 1);
    check("R13", "pending", pending_o, 0);
    check("R13", "alloc_idx", alloc_idx_o, 0);
    check("R6", "next_ready empty", next_ready_o, 16'hffff);
    check("R6", "issue_valid empty", issue_valid_o, 0);
  endtask

  task automatic t_fill;
    check("R5", "alloc_idx first", alloc_idx_o, 0);
    cmd(3'd0, 0, 0, 16'h0010, 0, 16'd50, 1);
    check("R3", "can_prefetch at 1", can_prefetch_o, 1);
    check("R5", "alloc_idx next", alloc_idx_o, 1);
    cmd(3'd0, 0, 0, 16'h0010, 1, 16'd60, 0);
    check("R3", "can_prefetch at 2", can_prefetch_o, 0);
    cmd(3'd0, 0, 0, 16'h0010, 0, 16'd70, 1);
    check("R2", "full at 3", full_o, 0);
    cmd(3'd0, 0, 0, 16'h0040, 0, 16'd80, 1);
    check("R1", "alloc_cnt at 4", alloc_cnt_o, 4);
    check("R1", "full at 4", full_o, 1);
    cmd(3'd0, 0, 0, 16'h0050, 0, 16'd90, 1);
    check("R2", "alloc_cnt after blocked alloc", alloc_cnt_o, 4);
    lookup("R2", 16'h0050, 0, 0, 0);
    check("R7", "head oldest", issue_idx_o, 0);
  endtask

  task automatic t_lookup;
    lookup("R4", 16'h0010, 0, 1, 0);
    lookup("R4", 16'h0010, 1, 1, 1);
    lookup("R4", 16'h0040, 1, 0, 0);
    lookup("R4", 16'h0040, 0, 1, 3);
    lookup("R4", 16'h0099, 0, 0, 0);
  endtask

  task automatic t_gate;
    now_i = 16'd40; #1;
    check("R6", "issue before time", issue_valid_o, 0);
    check("R6", "next_ready head", next_ready_o, 50);
    now_i = 16'd50; #1;
    check("R6", "issue at time", issue_valid_o, 1);
    check("R6", "issue addr", issue_addr_o, 16'h0010);
    now_i = 16'd1000; #1;
  endtask

  task automatic t_sent;
    cmd(3'd1, 0, 0, 0, 0, 0, 0);
    check("R8", "insvc after sent", insvc_cnt_o, 1);
    check("R8", "alloc kept", alloc_cnt_o, 4);
    check("R8", "head advanced", issue_idx_o, 1);
    cmd(3'd1, 1, 0, 0, 0, 0, 0);
    check("R8", "no-reply freed", alloc_cnt_o, 3);
    check("R8", "insvc unchanged", insvc_cnt_o, 1);
    check("R2", "full cleared", full_o, 0);
    check("R5", "freed slot reused", alloc_idx_o, 1);
    check("R8", "head next", issue_idx_o, 2);
    lookup("R8", 16'h0010, 1, 0, 0);
  endtask

  task automatic t_front_resend;
    cmd(3'd3, 3, 0, 0, 0, 0, 0);
    check("R10", "front head", issue_idx_o, 3);
    cmd(3'd3, 0, 0, 0, 0, 0, 0);
    check("R10", "front on sent ignored", issue_idx_o, 3);
    check("R10", "insvc kept", insvc_cnt_o, 1);
    cmd(3'd2, 0, 0, 0, 0, 0, 0);
    check("R9", "insvc after resend", insvc_cnt_o, 0);
    check("R9", "head unchanged", issue_idx_o, 3);
  endtask

  task automatic t_free;
    cmd(3'd4, 3, 0, 0, 0, 0, 0);
    check("R11", "alloc after free", alloc_cnt_o, 2);
    check("R11", "head after free", issue_idx_o, 2);
    check("R3", "can_prefetch at 2", can_prefetch_o, 0);
    cmd(3'd1, 2, 0, 0, 0, 0, 0);
    check("R9", "resent slot at tail", issue_idx_o, 0);
    cmd(3'd4, 2, 0, 0, 0, 0, 0);
    check("R11", "free sent alloc", alloc_cnt_o, 1);
    check("R11", "free sent insvc", insvc_cnt_o, 0);
    check("R3", "can_prefetch at 1", can_prefetch_o, 1);
  endtask

  task automatic t_squash;
    cmd(3'd0, 0, 1, 16'h0111, 0, 16'd10, 1);
    cmd(3'd0, 0, 1, 16'h0222, 0, 16'd20, 1);
    cmd(3'd0, 0, 2, 16'h0333, 0, 16'd30, 1);
    cmd(3'd1, 2, 0, 0, 0, 0, 0);
    cmd(3'd5, 0, 1, 0, 0, 0, 0);
    check("R12", "alloc after squash", alloc_cnt_o, 3);
    check("R12", "sent slot survives", insvc_cnt_o, 1);
    lookup("R12", 16'h0111, 0, 0, 0);
    lookup("R12", 16'h0222, 0, 1, 2);
    cmd(3'd4, 0, 0, 0, 0, 0, 0);
    check("R12", "squashed slot left queue", issue_idx_o, 3);
    cmd(3'd4, 3, 0, 0, 0, 0, 0);
    check("R6", "pending empty", pending_o, 0);
    check("R6", "next_ready max", next_ready_o, 16'hffff);
    cmd(3'd4, 2, 0, 0, 0, 0, 0);
    check("R11", "all free", alloc_cnt_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; now_i = '0; cmd_valid_i = 1'b0; cmd_op_i = '0; cmd_idx_i = '0;
    cmd_tid_i = '0; alloc_addr_i = '0; alloc_secure_i = 1'b0; alloc_ready_i = '0;
    alloc_resp_i = 1'b0; lk_addr_i = '0; lk_secure_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_lookup();
    t_gate();
    t_sent();
    t_front_resend();
    t_free();
    t_squash();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule